// File: doc/BRIEF.md
# Interrupt Source Gateway

This block sits between one external interrupt wire and the pending-bit logic of an interrupt controller. It first synchronises the raw line to the local clock. It then turns the activity on that line into single-cycle request pulses. After each pulse it marks the source as in flight, and it sends nothing more for that source until the controller's completion pulse comes back.

A static select puts each source in edge mode or level mode. In level mode, a request is raised whenever the source is idle and the synchronised line is high. This means that after completion the source asks again only if the line is still asserted.

In edge mode, a rising edge on an idle source makes a request. A second select decides what happens to rising edges that arrive while the source is in flight:

- In queue mode they are counted in a small saturating counter. Each later completion replays one of them as a new request.
- In drop mode they are thrown away.

Top module: `irq_gateway`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_o` is low. Reset also leaves the source not in flight with no stored edges, so a completion pulse given right after reset produces no request.
- R2: In edge mode (`trig_edge_i`=1) a rising edge of `irq_raw_i` on an idle source gives exactly one request. The request appears SYNC_STAGES+1 clock edges after the edge on which the new input level is first sampled.
- R3: Once a request has been issued, no further request is issued for the source until `done_i` has been sampled high. This holds whatever `irq_raw_i` does in the meantime.
- R4: In queue mode (`edge_queue_i`=1), rising edges seen while the source is in flight are stored. Each completion then replays one stored edge, and the request appears two clock edges after the edge that samples `done_i`. Once the store is empty, a completion produces no request.
- R5: The store of pending edges holds at most MAX_PENDING entries. Edges that arrive while it is full are lost, so exactly MAX_PENDING replays follow.
- R6: In drop mode (`edge_queue_i`=0), rising edges seen while the source is in flight are discarded, and the completion that follows produces no request.
- R7: In level mode (`trig_edge_i`=0), an idle source whose synchronised input is high issues a request on the next clock edge.
- R8: In level mode, a completion leads to a new request only if the input is still high. If the input has dropped by then, no request follows.
- R9: A completion pulse on a source that is not in flight is ignored: it produces no request and does not affect the next genuine request.
- R10: Every request on `req_o` lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw_i | input | 1 | Raw asynchronous interrupt line |
| trig_edge_i | input | 1 | 1 selects edge mode, 0 selects level mode |
| edge_queue_i | input | 1 | Edge mode only: 1 stores edges seen while in flight, 0 drops them |
| done_i | input | 1 | One-cycle completion pulse for this source |
| req_o | output | 1 | One-cycle request toward the pending-bit logic |

## Verification
The bench builds the gateway with MAX_PENDING set to 3 and SYNC_STAGES left at 2. The small store fills after a handful of edges, so the saturation boundary of R5 can be reached in a short run: five edges pushed into three slots must give exactly three replays and then silence. The two-stage synchroniser fixes the latency from input change to request at three edges, and that figure is the expected timing for every edge and level request in the scoreboard.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    // Conditioned view of the synchronised source line.
    typedef struct packed {
        logic level;
        logic rise;
    } sense_t;

    // Width of a counter that must hold values 0..maxv.
    function automatic int unsigned cnt_width(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/irq_gw_sync.sv
module irq_gw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_gw_sense.sv
module irq_gw_sense
    import irq_gw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   level_i,
    output sense_t sense_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_i;
    end

    always_comb begin
        sense_o.level = level_i;
        sense_o.rise  = level_i & ~prev_q;
    end
endmodule

// File: rtl/irq_gw_pend.sv
module irq_gw_pend
    import irq_gw_pkg::*;
#(
    parameter int unsigned MAX_PENDING = 7,
    localparam int unsigned CW = cnt_width(MAX_PENDING)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable_i,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic          nonzero_o,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] CAP = CW'(MAX_PENDING);

    logic [CW-1:0] count_q, count_d;

    always_comb begin
        count_d = count_q;
        if (!enable_i) begin
            count_d = '0;
        end else begin
            unique case ({inc_i, dec_i})
                2'b10:   count_d = (count_q == CAP) ? count_q : count_q + 1'b1;
                2'b01:   count_d = (count_q == '0) ? count_q : count_q - 1'b1;
                default: count_d = count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count_o   = count_q;
    assign nonzero_o = (count_q != '0);

    assert_sat_bound_R5: assert property (@(posedge clk) disable iff (rst)
        count_q <= CAP);

    assert_sat_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (enable_i && inc_i && !dec_i && count_q == CAP) |=> (count_q == CAP));

    assert_drop_empty_R6: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (count_q == '0));
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
    import irq_gw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MAX_PENDING = 7,
    localparam int unsigned CW = cnt_width(MAX_PENDING)
) (
    input  logic clk,
    input  logic rst,
    input  logic irq_raw_i,
    input  logic trig_edge_i,
    input  logic edge_queue_i,
    input  logic done_i,
    output logic req_o
);
    trig_e         mode;
    logic          level_s;
    sense_t        sense;
    logic          busy_q;
    logic          req_q;
    logic          fire;
    logic          queue_en;
    logic          pend_inc, pend_dec, pend_nz;
    logic [CW-1:0] pend_cnt;

    assign mode     = trig_e'(trig_edge_i);
    assign queue_en = (mode == TRIG_EDGE) && edge_queue_i;

    irq_gw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (irq_raw_i),
        .q_o (level_s)
    );

    irq_gw_sense u_sense (
        .clk     (clk),
        .rst     (rst),
        .level_i (level_s),
        .sense_o (sense)
    );

    // A new edge is stored whenever it cannot be served directly.
    assign pend_inc = sense.rise && queue_en && (busy_q || pend_nz);
    assign pend_dec = fire && pend_nz;

    irq_gw_pend #(.MAX_PENDING(MAX_PENDING)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .enable_i  (queue_en),
        .inc_i     (pend_inc),
        .dec_i     (pend_dec),
        .nonzero_o (pend_nz),
        .count_o   (pend_cnt)
    );

    always_comb begin
        fire = 1'b0;
        if (!busy_q) begin
            if (mode == TRIG_EDGE) fire = sense.rise || pend_nz;
            else                   fire = sense.level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            req_q <= fire;
            if (fire)        busy_q <= 1'b1;
            else if (done_i) busy_q <= 1'b0;
        end
    end

    assign req_o = req_q;

    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !req_o);

    assert_hold_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done_i) |=> !req_o);

    assert_level_fire_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && mode == TRIG_LEVEL && level_s) |=> req_o);

    assert_single_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

    assert_req_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
        req_o |-> busy_q);

    assert_pend_width_R5: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= CW'(MAX_PENDING));
endmodule

// File: tb/test_irq_gateway.sv
module test_irq_gateway;

    localparam int unsigned SYNC   = 2;
    localparam int unsigned MAXP   = 3;
    localparam int          LAT_IN = SYNC + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_raw = 1'b0;
    logic trig_edge = 1'b1;
    logic edge_queue = 1'b1;
    logic done = 1'b0;
    logic req;

    always #5 clk = ~clk;

    irq_gateway #(.SYNC_STAGES(SYNC), .MAX_PENDING(MAXP)) i_irq_gateway (
        .clk          (clk),
        .rst          (rst),
        .irq_raw_i    (irq_raw),
        .trig_edge_i  (trig_edge),
        .edge_queue_i (edge_queue),
        .done_i       (done),
        .req_o        (req)
    );

    typedef struct {
        int    cyc;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    string phase = "R1";
    bit    reported = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Monitor: compare each output cycle with the scoreboard.
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                checks++; fails++;
                $display("FAIL %s: request missing at cycle %0d, actual 0 expected 1",
                         exp_q[0].tag, exp_q[0].cyc);
                void'(exp_q.pop_front());
            end
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                checks++;
                if (req !== 1'b1) begin
                    fails++;
                    $display("FAIL %s: cycle %0d req actual %b expected 1",
                             exp_q[0].tag, cyc, req);
                end
                void'(exp_q.pop_front());
            end else if (req !== 1'b0) begin
                checks++; fails++;
                $display("FAIL %s: cycle %0d unexpected req actual %b expected 0",
                         phase, cyc, req);
            end
        end
    end

    task automatic expect_at(input int at, input string tag);
        exp_t e;
        e.cyc = at;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic edge_pulse(input string tag, input bit want);
        @(negedge clk);
        phase = tag;
        irq_raw = 1'b1;
        if (want) expect_at(cyc + LAT_IN, tag);
        repeat (3) @(negedge clk);
        irq_raw = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic complete(input string tag, input bit want);
        @(negedge clk);
        phase = tag;
        done = 1'b1;
        if (want) expect_at(cyc + 2, tag);
        @(negedge clk);
        done = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string tag);
        phase = tag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            checks++;
            if (req !== 1'b0) begin
                fails++;
                $display("FAIL %s: quiet window req actual %b expected 0", tag, req);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        report();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        checks++;
        if (req !== 1'b0) begin
            fails++;
            $display("FAIL R1: req during reset actual %b expected 0", req);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (req !== 1'b0) begin
            fails++;
            $display("FAIL R1: req after reset actual %b expected 0", req);
        end
        complete("R1", 0);
        quiet(4, "R1");

        // R2, R3, R4: edge mode with queueing
        trig_edge = 1'b1; edge_queue = 1'b1;
        edge_pulse("R2", 1);
        edge_pulse("R3", 0);
        edge_pulse("R3", 0);
        quiet(3, "R3");
        complete("R4", 1);
        complete("R4", 1);
        complete("R4", 0);
        quiet(5, "R4");

        // R5: store saturates at MAXP
        edge_pulse("R5", 1);
        for (int k = 0; k < 5; k++) edge_pulse("R5", 0);
        for (int k = 0; k < MAXP; k++) complete("R5", 1);
        complete("R5", 0);
        quiet(5, "R5");

        // R6: drop mode discards edges while in flight
        edge_queue = 1'b0;
        edge_pulse("R6", 1);
        edge_pulse("R6", 0);
        edge_pulse("R6", 0);
        complete("R6", 0);
        quiet(5, "R6");
        edge_pulse("R6", 1);
        complete("R6", 0);

        // R7, R8: level mode
        trig_edge = 1'b0;
        @(negedge clk);
        phase = "R7";
        irq_raw = 1'b1;
        expect_at(cyc + LAT_IN, "R7");
        repeat (6) @(negedge clk);
        complete("R8", 1);
        @(negedge clk);
        irq_raw = 1'b0;
        repeat (4) @(negedge clk);
        complete("R8", 0);
        quiet(5, "R8");

        // R9: completion on an idle source is ignored
        trig_edge = 1'b1; edge_queue = 1'b1;
        complete("R9", 0);
        complete("R9", 0);
        edge_pulse("R9", 1);
        quiet(3, "R10");
        complete("R9", 0);
        quiet(5, "R9");

        repeat (2) @(negedge clk);
        while (exp_q.size() > 0) begin
            checks++; fails++;
            $display("FAIL %s: request never seen at cycle %0d, actual 0 expected 1",
                     exp_q[0].tag, exp_q[0].cyc);
            void'(exp_q.pop_front());
        end
        report();
    end
endmodule